// File: doc/BRIEF.md
# Calendar-Day Real-Time Clock with Alarm

A register-mapped real-time clock that keeps the time of day as separate second, minute and hour fields plus a day count. All four fields advance together on a one-cycle strobe that arrives once per second from outside the block. A second register set holds an alarm time in the same format. When a step of the clock lands exactly on the alarm time, a status flag is raised. Another status flag is raised on every step.

Software reaches the block through a 16-bit read/write port addressed by byte offset. Reads are combinational. Writes take effect at the next clock edge. The status flags are cleared by writing ones, and an enable register picks which flags drive the single interrupt line. The day field is 9 bits wide by default, and a parameter can widen it to 16 bits.

Top module: `rtc_dhms`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Register offsets:
  - 0x00: hours in bits 15:8 and minutes in bits 7:0.
  - 0x04: seconds.
  - 0x08: alarm hours and minutes, in the 0x00 layout.
  - 0x0C: alarm seconds.
  - 0x10: control.
  - 0x14: status.
  - 0x18: interrupt enable.
  - 0x20: day.
  - 0x24: alarm day.

  With no step pending, a written value reads back from its own offset. Unmapped offsets read 0.
- R3: In the control register, bit 7 is the run enable and bits 6:5 are a reference-rate select (0 = 32768 Hz, 1 = 32000 Hz, 2 = 38400 Hz). Both read back as written, and every other control bit reads 0.
- R4: A step of `tick_1hz` while running advances the time by one second:
  - Seconds go from 59 to 0 and carry into minutes.
  - Minutes go from 59 to 0 and carry into hours.
  - Hours go from 23 to 0 and carry into the day.
- R5: The day field counts modulo 2^DAY_W. A write keeps only its low DAY_W bits, so with the default 9 bits, day 511 steps to 0 and a write of 0xFFFF reads back as 0x01FF.
- R6: While the run bit is 0, a tick changes no time field and sets no status flag.
- R7: When a tick arrives in the same cycle as a write to offset 0x00, 0x04 or 0x20, the write is applied and that tick's time step is discarded.
- R8: Status bit 2 (alarm) is set when a running step makes day, hours, minutes and seconds all equal to the alarm registers. A bus write that makes the time equal to the alarm does not set it.
- R9: Status bit 4 (one-second) is set on every tick while running.
- R10: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event sets a bit in the same cycle as a write clears it, the bit stays set.
- R11: `irq` is high exactly when some status bit and the same bit of the enable register are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| bus_addr | input | 6 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a time step and a software write to a time field. The bench raises `tick_1hz` in the cycle in which it writes the seconds register. It then expects the written value to read back, with no increment and with the other fields unchanged.

The second pair is the alarm event and a write-one-to-clear of the same status bit. The bench sets the time one second before the alarm and issues the clearing write to the status register together with the tick. It then expects both the alarm flag and the one-second flag to read as set. A following write of 0 must leave them set, and a write of 1 to bit 2 alone must leave only bit 4.

// File: rtl/rtc_dhms_pkg.sv
package rtc_dhms_pkg;

    // Byte offsets of the register map
    localparam logic [5:0] OFS_HM   = 6'h00;
    localparam logic [5:0] OFS_SEC  = 6'h04;
    localparam logic [5:0] OFS_AHM  = 6'h08;
    localparam logic [5:0] OFS_ASEC = 6'h0C;
    localparam logic [5:0] OFS_CTRL = 6'h10;
    localparam logic [5:0] OFS_STAT = 6'h14;
    localparam logic [5:0] OFS_IEN  = 6'h18;
    localparam logic [5:0] OFS_DAY  = 6'h20;
    localparam logic [5:0] OFS_ADAY = 6'h24;

    // Field widths of the time of day
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;

    // Bit positions in the control and status registers
    localparam int BIT_ALM   = 2;
    localparam int BIT_SEC1  = 4;
    localparam int BIT_RUN   = 7;
    localparam int REFSEL_LO = 5;

    // Hours, minutes and seconds held together
    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } hms_t;

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_dhms_pkg::*;
#(
    parameter int DAY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wr_hm,
    input  logic             wr_sec,
    input  logic             wr_day,
    input  hms_t             wval_hms,
    input  logic [DAY_W-1:0] wval_day,
    output hms_t             hms_q,
    output logic [DAY_W-1:0] day_q,
    output hms_t             step_hms,
    output logic [DAY_W-1:0] step_day
);

    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
    localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
    localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);

    typedef struct packed {
        logic [DAY_W-1:0] day;
        hms_t             hms;
    } tstate_t;

    tstate_t st_q, st_d, inc;
    logic    c_sec, c_min, c_hour;

    always_comb begin
        inc    = st_q;
        c_sec  = (st_q.hms.sec == SEC_LAST);
        c_min  = c_sec && (st_q.hms.min == MIN_LAST);
        c_hour = c_min && (st_q.hms.hour == HOUR_LAST);

        // Seconds, then the carry chain upward
        inc.hms.sec = c_sec ? '0 : st_q.hms.sec + 1'b1;
        if (c_sec) begin
            inc.hms.min = c_min ? '0 : st_q.hms.min + 1'b1;
        end
        if (c_min) begin
            inc.hms.hour = c_hour ? '0 : st_q.hms.hour + 1'b1;
        end
        if (c_hour) begin
            inc.day = st_q.day + 1'b1;
        end

        // A step first, then bus writes on top of it
        st_d = st_q;
        if (adv) begin
            st_d = inc;
        end
        if (wr_hm) begin
            st_d.hms.hour = wval_hms.hour;
            st_d.hms.min  = wval_hms.min;
        end
        if (wr_sec) begin
            st_d.hms.sec = wval_hms.sec;
        end
        if (wr_day) begin
            st_d.day = wval_day;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hms_q    = st_q.hms;
    assign day_q    = st_q.day;
    assign step_hms = inc.hms;
    assign step_day = inc.day;

    // R4
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_sec && hms_q.sec < SEC_LAST) |=> hms_q.sec == $past(hms_q.sec) + 1'b1);

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_sec && hms_q.sec == SEC_LAST) |=> hms_q.sec == '0);

    // R5
    day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_day && (&day_q) && hms_q.hour == HOUR_LAST &&
         hms_q.min == MIN_LAST && hms_q.sec == SEC_LAST) |=> day_q == '0);

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_dhms_pkg::*;
#(
    parameter int DAY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ahm,
    input  logic             wr_asec,
    input  logic             wr_aday,
    input  hms_t             wval_hms,
    input  logic [DAY_W-1:0] wval_day,
    input  logic             adv,
    input  hms_t             cand_hms,
    input  logic [DAY_W-1:0] cand_day,
    output hms_t             alm_hms,
    output logic [DAY_W-1:0] alm_day,
    output logic             hit
);

    typedef struct packed {
        logic [DAY_W-1:0] day;
        hms_t             hms;
    } astate_t;

    astate_t al_q, al_d;

    always_comb begin
        al_d = al_q;
        if (wr_ahm) begin
            al_d.hms.hour = wval_hms.hour;
            al_d.hms.min  = wval_hms.min;
        end
        if (wr_asec) begin
            al_d.hms.sec = wval_hms.sec;
        end
        if (wr_aday) begin
            al_d.day = wval_day;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q <= '0;
        end else begin
            al_q <= al_d;
        end
    end

    // The compare looks at the value the step is about to load
    assign hit     = adv && (cand_hms == al_q.hms) && (cand_day == al_q.day);
    assign alm_hms = al_q.hms;
    assign alm_day = al_q.day;

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_dhms_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_alarm,
    input  logic              ev_sec,
    input  logic              wr_stat,
    input  logic              wr_ien,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] ien_q,
    output logic              irq
);

    localparam logic [DATA_W-1:0] STAT_MASK =
        (DATA_W'(1) << BIT_ALM) | (DATA_W'(1) << BIT_SEC1);

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] ien;
    } istate_t;

    istate_t           is_q, is_d;
    logic [DATA_W-1:0] set_v, clr_v;

    always_comb begin
        set_v           = '0;
        set_v[BIT_ALM]  = ev_alarm;
        set_v[BIT_SEC1] = ev_sec;
        clr_v           = wr_stat ? wdata : '0;

        is_d      = is_q;
        // An event in the same cycle as a clear wins
        is_d.stat = ((is_q.stat & ~clr_v) | set_v) & STAT_MASK;
        if (wr_ien) begin
            is_d.ien = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_q <= '0;
        end else begin
            is_q <= is_d;
        end
    end

    assign stat_q = is_q.stat;
    assign ien_q  = is_q.ien;
    assign irq    = |(is_q.stat & is_q.ien);

    // R10
    w1c_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[BIT_ALM] && !ev_alarm) |=> !stat_q[BIT_ALM]);

    // R10
    zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[BIT_ALM] && !(wr_stat && wdata[BIT_ALM])) |=> stat_q[BIT_ALM]);

    // R8
    alarm_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_alarm |=> stat_q[BIT_ALM]);

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

endmodule

// File: rtl/rtc_dhms.sv
module rtc_dhms
    import rtc_dhms_pkg::*;
#(
    parameter int DAY_W  = 9,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    typedef struct packed {
        logic       run;
        logic [1:0] refsel;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday;
    logic wr_ctrl, wr_stat, wr_ien, time_wr;
    logic adv, ev_sec, hit;

    hms_t              wval_hms, hms_q, step_hms, alm_hms;
    logic [DAY_W-1:0]  wval_day, day_q, step_day, alm_day;
    logic [DATA_W-1:0] stat_q, ien_q;

    // Address decode
    always_comb begin
        wr_hm   = bus_we && (bus_addr == OFS_HM);
        wr_sec  = bus_we && (bus_addr == OFS_SEC);
        wr_day  = bus_we && (bus_addr == OFS_DAY);
        wr_ahm  = bus_we && (bus_addr == OFS_AHM);
        wr_asec = bus_we && (bus_addr == OFS_ASEC);
        wr_aday = bus_we && (bus_addr == OFS_ADAY);
        wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
        wr_stat = bus_we && (bus_addr == OFS_STAT);
        wr_ien  = bus_we && (bus_addr == OFS_IEN);
        time_wr = wr_hm || wr_sec || wr_day;

        // A time write drops the step of that cycle
        adv    = tick_1hz && ctl_q.run && !time_wr;
        ev_sec = tick_1hz && ctl_q.run;

        wval_hms.hour = bus_wdata[8 +: HOUR_W];
        wval_hms.min  = bus_wdata[0 +: MIN_W];
        wval_hms.sec  = bus_wdata[0 +: SEC_W];
        wval_day      = bus_wdata[0 +: DAY_W];
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.run    = bus_wdata[BIT_RUN];
            ctl_d.refsel = bus_wdata[REFSEL_LO +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rtc_time_core #(.DAY_W(DAY_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .wr_hm    (wr_hm),
        .wr_sec   (wr_sec),
        .wr_day   (wr_day),
        .wval_hms (wval_hms),
        .wval_day (wval_day),
        .hms_q    (hms_q),
        .day_q    (day_q),
        .step_hms (step_hms),
        .step_day (step_day)
    );

    rtc_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ahm   (wr_ahm),
        .wr_asec  (wr_asec),
        .wr_aday  (wr_aday),
        .wval_hms (wval_hms),
        .wval_day (wval_day),
        .adv      (adv),
        .cand_hms (step_hms),
        .cand_day (step_day),
        .alm_hms  (alm_hms),
        .alm_day  (alm_day),
        .hit      (hit)
    );

    rtc_irq_unit #(.DATA_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_alarm (hit),
        .ev_sec   (ev_sec),
        .wr_stat  (wr_stat),
        .wr_ien   (wr_ien),
        .wdata    (bus_wdata),
        .stat_q   (stat_q),
        .ien_q    (ien_q),
        .irq      (irq)
    );

    // Read-back multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_HM: begin
                bus_rdata[8 +: HOUR_W] = hms_q.hour;
                bus_rdata[0 +: MIN_W]  = hms_q.min;
            end
            OFS_SEC:  bus_rdata[0 +: SEC_W] = hms_q.sec;
            OFS_AHM: begin
                bus_rdata[8 +: HOUR_W] = alm_hms.hour;
                bus_rdata[0 +: MIN_W]  = alm_hms.min;
            end
            OFS_ASEC: bus_rdata[0 +: SEC_W] = alm_hms.sec;
            OFS_CTRL: begin
                bus_rdata[BIT_RUN]          = ctl_q.run;
                bus_rdata[REFSEL_LO +: 2]   = ctl_q.refsel;
            end
            OFS_STAT: bus_rdata = stat_q;
            OFS_IEN:  bus_rdata = ien_q;
            OFS_DAY:  bus_rdata[0 +: DAY_W] = day_q;
            OFS_ADAY: bus_rdata[0 +: DAY_W] = alm_day;
            default:  bus_rdata = '0;
        endcase
    end

    // R6
    frozen_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !time_wr) |=> ($stable(hms_q) && $stable(day_q)));

    // R6
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !stat_q[BIT_SEC1]) |=> !stat_q[BIT_SEC1]);

    // R7
    write_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sec && tick_1hz) |=> hms_q.sec == $past(bus_wdata[SEC_W-1:0]));

endmodule

// File: tb/tb_rtc_dhms.sv
module tb_rtc_dhms;

    localparam logic [1:0] K_WR = 2'd0, K_TICK = 2'd1, K_EXP = 2'd2, K_IRQ = 2'd3;

    function automatic logic [27:0] mk(input logic [1:0] k, input logic [3:0] r,
                                       input logic [5:0] a, input logic [15:0] d);
        return {k, r, a, d};
    endfunction

    localparam int NV = 34;
    // R2 R3 R4 R6 R9 R10 R11 exercised by this table
    localparam logic [27:0] VEC [NV] = '{
        mk(K_WR,   4'd3,  6'h10, 16'h0080),
        mk(K_WR,   4'd2,  6'h00, 16'h173B),
        mk(K_WR,   4'd2,  6'h04, 16'h003A),
        mk(K_WR,   4'd2,  6'h20, 16'h0005),
        mk(K_EXP,  4'd2,  6'h00, 16'h173B),
        mk(K_EXP,  4'd2,  6'h04, 16'h003A),
        mk(K_EXP,  4'd2,  6'h20, 16'h0005),
        mk(K_TICK, 4'd4,  6'h00, 16'h0000),
        mk(K_EXP,  4'd4,  6'h04, 16'h003B),
        mk(K_EXP,  4'd9,  6'h14, 16'h0010),
        mk(K_TICK, 4'd4,  6'h00, 16'h0000),
        mk(K_EXP,  4'd4,  6'h04, 16'h0000),
        mk(K_EXP,  4'd4,  6'h00, 16'h0000),
        mk(K_EXP,  4'd4,  6'h20, 16'h0006),
        mk(K_WR,   4'd10, 6'h14, 16'h0010),
        mk(K_EXP,  4'd10, 6'h14, 16'h0000),
        mk(K_WR,   4'd3,  6'h10, 16'hFFC0),
        mk(K_EXP,  4'd3,  6'h10, 16'h00C0),
        mk(K_WR,   4'd3,  6'h10, 16'h0020),
        mk(K_EXP,  4'd3,  6'h10, 16'h0020),
        mk(K_TICK, 4'd6,  6'h00, 16'h0000),
        mk(K_EXP,  4'd6,  6'h04, 16'h0000),
        mk(K_EXP,  4'd6,  6'h14, 16'h0000),
        mk(K_WR,   4'd3,  6'h10, 16'h0080),
        mk(K_WR,   4'd2,  6'h18, 16'h0010),
        mk(K_EXP,  4'd2,  6'h18, 16'h0010),
        mk(K_EXP,  4'd2,  6'h3C, 16'h0000),
        mk(K_IRQ,  4'd11, 6'h00, 16'h0000),
        mk(K_TICK, 4'd4,  6'h00, 16'h0000),
        mk(K_EXP,  4'd4,  6'h04, 16'h0001),
        mk(K_IRQ,  4'd11, 6'h00, 16'h0001),
        mk(K_WR,   4'd10, 6'h14, 16'h0010),
        mk(K_IRQ,  4'd11, 6'h00, 16'h0000),
        mk(K_EXP,  4'd10, 6'h14, 16'h0000)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_dhms dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Write and tick in the same cycle
    task automatic wr_tick(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d; tick = 1'b1;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        n_checks++;
        if (rdata !== exp) begin
            n_errors++;
            $display("FAIL %s addr %h actual %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        #1;
        n_checks++;
        if (irq !== exp) begin
            n_errors++;
            $display("FAIL %s irq actual %b expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        foreach (VEC[i]) begin end
        for (int a = 0; a < 10; a++) begin
            chk("R1", (a < 9) ? 6'(a * 4) : 6'h24, 16'h0000);
        end
        chk_irq("R1", 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [3:0]  r;
            logic [5:0]  a;
            logic [15:0] d;
            string       tg;
            {k, r, a, d} = VEC[i];
            tg = $sformatf("R%0d", r);
            case (k)
                K_WR:    wr(a, d);
                K_TICK:  step();
                K_EXP:   chk(tg, a, d);
                default: chk_irq(tg, d[0]);
            endcase
        end

        // R7: write to seconds with a tick in the same cycle
        wr_tick(6'h04, 16'h0014);
        chk("R7", 6'h04, 16'h0014);
        chk("R7", 6'h00, 16'h0000);
        chk("R7", 6'h20, 16'h0006);

        // R5: day wraps at 2^9 and writes keep the low bits
        wr(6'h20, 16'h01FF);
        wr(6'h00, 16'h173B);
        wr(6'h04, 16'h003B);
        step();
        chk("R5", 6'h20, 16'h0000);
        chk("R4", 6'h00, 16'h0000);
        chk("R4", 6'h04, 16'h0000);
        wr(6'h20, 16'hFFFF);
        chk("R5", 6'h20, 16'h01FF);

        // R8: alarm set only by a step, not by a write
        wr(6'h18, 16'h0000);
        wr(6'h14, 16'hFFFF);
        wr(6'h24, 16'h0003);
        wr(6'h08, 16'h0A14);
        wr(6'h0C, 16'h001F);
        chk("R2", 6'h24, 16'h0003);
        chk("R2", 6'h08, 16'h0A14);
        chk("R2", 6'h0C, 16'h001F);
        wr(6'h20, 16'h0003);
        wr(6'h00, 16'h0A14);
        wr(6'h04, 16'h001F);
        chk("R8", 6'h14, 16'h0000);
        wr(6'h04, 16'h001E);
        step();
        chk("R8", 6'h04, 16'h001F);
        chk("R8", 6'h14, 16'h0014);
        chk_irq("R11", 1'b0);
        wr(6'h18, 16'h0004);
        chk_irq("R11", 1'b1);
        wr(6'h14, 16'h0014);
        chk("R10", 6'h14, 16'h0000);
        chk_irq("R11", 1'b0);

        // R10: alarm event and clear in the same cycle
        wr(6'h04, 16'h001E);
        wr_tick(6'h14, 16'h0014);
        chk("R10", 6'h14, 16'h0014);
        wr(6'h14, 16'h0000);
        chk("R10", 6'h14, 16'h0014);
        wr(6'h14, 16'h0004);
        chk("R10", 6'h14, 16'h0010);

        // R6: stopped clock raises no alarm
        wr(6'h14, 16'hFFFF);
        wr(6'h10, 16'h0000);
        wr(6'h04, 16'h001E);
        step();
        chk("R6", 6'h04, 16'h001E);
        chk("R6", 6'h14, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule